// File: doc/BRIEF.md
# Process-Tagged Address Translator

This block translates virtual addresses that live in one global address space. Every virtual address carries a process number in its top bits. The bits below it are a page number and a page offset. The page number is looked up in a page table that belongs to the named process. The page offset is appended unchanged to the physical frame number from that entry.

A process number of zero does not select a table of its own. It stands for "the running process": the block substitutes the value of its current-process register before the table is indexed. Code can therefore address its own space without knowing which process it is. A nonzero process number reaches the named process's space directly.

Page-table entries are written through a dedicated write port. The current-process register has a write port of its own. Each accepted lookup produces a response one clock later. The response carries the physical address and a fault flag, and one lookup can be accepted every cycle.

Top module: `xlat_unit`

## Requirements
- R1: A 20-bit virtual address is split into a process number in bits [19:16], a page number in bits [15:12] and an offset in bits [11:0]. The physical address is {frame[7:0], offset[11:0]}.
- R2: A lookup with a nonzero process number uses the entry of that process and page, whatever the current-process register holds.
- R3: A lookup with process number zero uses the entry of the process held in the current-process register and the requested page.
- R4: The current-process register resets to 1. A write of a nonzero value takes effect for lookups accepted in the following cycles. A lookup in the same cycle as the write still uses the old value.
- R5: A write of zero to the current-process register is ignored, so the register never holds zero.
- R6: Each entry holds a valid bit, a write-permission bit and an 8-bit frame number. An entry write with process number zero targets the current process's entry.
- R7: A lookup faults when the entry's valid bit is 0. It also faults when the request is a write and the entry's write-permission bit is 0. A read of a valid entry without write permission does not fault.
- R8: A faulting response drives a physical address of zero.
- R9: The response valid is asserted exactly one clock after each accepted request. Back-to-back requests give back-to-back responses.
- R10: An entry write and a lookup of the same entry in the same cycle return the entry's old contents. Later lookups see the new contents.
- R11: After reset the response valid is low and every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request valid |
| req_vaddr_i | input | 20 | Virtual address: process, page, offset |
| req_wr_i | input | 1 | Request is a write access |
| rsp_valid_o | output | 1 | Response valid |
| rsp_paddr_o | output | 20 | Physical address, zero on fault |
| rsp_fault_o | output | 1 | Translation or permission fault |
| pte_we_i | input | 1 | Entry write strobe |
| pte_pid_i | input | 4 | Entry process number, zero means current process |
| pte_vpn_i | input | 4 | Entry page number |
| pte_valid_i | input | 1 | Entry valid bit |
| pte_wperm_i | input | 1 | Entry write-permission bit |
| pte_pfn_i | input | 8 | Entry frame number |
| cur_we_i | input | 1 | Current-process register write strobe |
| cur_wdata_i | input | 4 | New current process number, zero ignored |

## Verification
A lookup can fall in the same cycle as an entry write or as a current-process update. Both collisions decide which table contents or which process identity the response reflects. The bench provokes each one deliberately. It writes the very entry a lookup reads, and it changes the current process while a process-zero lookup and a process-zero entry write are in flight. Randomized traffic then repeats these collisions many times. A behavioural model applies every write only after it has formed the expected response, so each collision is judged against the old-contents and old-process rules.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int unsigned PID_W = 4;
  localparam int unsigned VPN_W = 4;
  localparam int unsigned OFF_W = 12;
  localparam int unsigned PFN_W = 8;
  localparam int unsigned VA_W  = PID_W + VPN_W + OFF_W;
  localparam int unsigned PA_W  = PFN_W + OFF_W;
  localparam int unsigned IDX_W = PID_W + VPN_W;
  localparam int unsigned N_ENT = 1 << IDX_W;

  typedef struct packed {
    logic             valid;
    logic             wperm;
    logic [PFN_W-1:0] pfn;
  } pte_t;
endpackage

// File: rtl/xlat_pid_resolve.sv
module xlat_pid_resolve import xlat_pkg::*; (
  input  logic [PID_W-1:0] pid_i,
  input  logic [PID_W-1:0] cur_i,
  output logic [PID_W-1:0] pid_o
);
  // zero is the self alias
  assign pid_o = (pid_i == '0) ? cur_i : pid_i;
endmodule

// File: rtl/xlat_cur_reg.sv
module xlat_cur_reg import xlat_pkg::*; #(
  parameter logic [PID_W-1:0] CUR_RST = PID_W'(1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [PID_W-1:0] wdata_i,
  output logic [PID_W-1:0] cur_o
);
  logic [PID_W-1:0] cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cur_q <= CUR_RST;
    else if (we_i && wdata_i != '0)   cur_q <= wdata_i;
  end

  assign cur_o = cur_q;
endmodule

// File: rtl/xlat_pte_store.sv
module xlat_pte_store import xlat_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  pte_t             wdata_i,
  input  logic [IDX_W-1:0] ridx_i,
  output pte_t             rdata_o
);
  pte_t mem_q [N_ENT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_ENT; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[widx_i] <= wdata_i;
    end
  end

  // read before write: same-edge update is not visible
  assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/xlat_rsp_stage.sv
module xlat_rsp_stage import xlat_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_wr_i,
  input  logic [OFF_W-1:0] req_off_i,
  input  pte_t             pte_i,
  output logic             rsp_valid_o,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic             rsp_fault_o
);
  logic fault_d;

  assign fault_d = !pte_i.valid || (req_wr_i && !pte_i.wperm);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_fault_o <= 1'b0;
      rsp_paddr_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_fault_o <= fault_d;
        rsp_paddr_o <= fault_d ? '0 : {pte_i.pfn, req_off_i};
      end
    end
  end
endmodule

// File: rtl/xlat_unit.sv
module xlat_unit import xlat_pkg::*; #(
  parameter logic [PID_W-1:0] CUR_RST = PID_W'(1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic             req_wr_i,
  output logic             rsp_valid_o,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic             rsp_fault_o,
  input  logic             pte_we_i,
  input  logic [PID_W-1:0] pte_pid_i,
  input  logic [VPN_W-1:0] pte_vpn_i,
  input  logic             pte_valid_i,
  input  logic             pte_wperm_i,
  input  logic [PFN_W-1:0] pte_pfn_i,
  input  logic             cur_we_i,
  input  logic [PID_W-1:0] cur_wdata_i
);
  localparam int unsigned OFF_LO = 0;
  localparam int unsigned VPN_LO = OFF_W;
  localparam int unsigned PID_LO = OFF_W + VPN_W;

  logic [PID_W-1:0] cur_pid_q;
  logic [PID_W-1:0] req_pid, req_pid_res, wr_pid_res;
  logic [VPN_W-1:0] req_vpn;
  logic [OFF_W-1:0] req_off;
  pte_t             pte_wdata, pte_rdata;

  assign req_pid = req_vaddr_i[PID_LO +: PID_W];
  assign req_vpn = req_vaddr_i[VPN_LO +: VPN_W];
  assign req_off = req_vaddr_i[OFF_LO +: OFF_W];

  xlat_cur_reg #(.CUR_RST(CUR_RST)) u_cur (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cur_we_i),
    .wdata_i (cur_wdata_i),
    .cur_o   (cur_pid_q)
  );

  xlat_pid_resolve u_req_pid (
    .pid_i (req_pid),
    .cur_i (cur_pid_q),
    .pid_o (req_pid_res)
  );

  xlat_pid_resolve u_wr_pid (
    .pid_i (pte_pid_i),
    .cur_i (cur_pid_q),
    .pid_o (wr_pid_res)
  );

  assign pte_wdata = '{valid: pte_valid_i, wperm: pte_wperm_i, pfn: pte_pfn_i};

  xlat_pte_store u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (pte_we_i),
    .widx_i  ({wr_pid_res, pte_vpn_i}),
    .wdata_i (pte_wdata),
    .ridx_i  ({req_pid_res, req_vpn}),
    .rdata_o (pte_rdata)
  );

  xlat_rsp_stage u_rsp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_wr_i    (req_wr_i),
    .req_off_i   (req_off),
    .pte_i       (pte_rdata),
    .rsp_valid_o (rsp_valid_o),
    .rsp_paddr_o (rsp_paddr_o),
    .rsp_fault_o (rsp_fault_o)
  );
endmodule

// File: rtl/xlat_unit_chk.sv
module xlat_unit_chk import xlat_pkg::*; (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [VA_W-1:0]  req_vaddr_i,
  input logic             rsp_valid_o,
  input logic [PA_W-1:0]  rsp_paddr_o,
  input logic             rsp_fault_o,
  input logic             cur_we_i,
  input logic [PID_W-1:0] cur_wdata_i,
  input logic [PID_W-1:0] cur_q_i
);
  a_r9_rsp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  a_r9_no_spurious_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  a_r8_fault_zero_pa: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o) |-> (rsp_paddr_o == '0));

  a_r1_offset_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (rsp_fault_o || rsp_paddr_o[OFF_W-1:0] == $past(req_vaddr_i[OFF_W-1:0])));

  a_r5_zero_load_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_we_i && cur_wdata_i == '0) |=> $stable(cur_q_i));

  a_r4_load_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_we_i && cur_wdata_i != '0) |=> (cur_q_i == $past(cur_wdata_i)));

  a_r5_cur_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_q_i != '0);
endmodule

bind xlat_unit xlat_unit_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_vaddr_i (req_vaddr_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_paddr_o (rsp_paddr_o),
  .rsp_fault_o (rsp_fault_o),
  .cur_we_i    (cur_we_i),
  .cur_wdata_i (cur_wdata_i),
  .cur_q_i     (cur_pid_q)
);

// File: tb/tb_xlat_unit.sv
module tb_xlat_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [19:0] req_vaddr = '0;
  logic        req_wr = 1'b0;
  logic        rsp_valid;
  logic [19:0] rsp_paddr;
  logic        rsp_fault;
  logic        pte_we = 1'b0;
  logic [3:0]  pte_pid = '0;
  logic [3:0]  pte_vpn = '0;
  logic        pte_valid = 1'b0;
  logic        pte_wperm = 1'b0;
  logic [7:0]  pte_pfn = '0;
  logic        cur_we = 1'b0;
  logic [3:0]  cur_wdata = '0;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // behavioural model
  bit m_v [16][16];
  bit m_w [16][16];
  int m_f [16][16];
  int m_cur = 1;

  always #4 clk = ~clk;

  xlat_unit dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_vaddr_i(req_vaddr), .req_wr_i(req_wr),
    .rsp_valid_o(rsp_valid), .rsp_paddr_o(rsp_paddr), .rsp_fault_o(rsp_fault),
    .pte_we_i(pte_we), .pte_pid_i(pte_pid), .pte_vpn_i(pte_vpn),
    .pte_valid_i(pte_valid), .pte_wperm_i(pte_wperm), .pte_pfn_i(pte_pfn),
    .cur_we_i(cur_we), .cur_wdata_i(cur_wdata)
  );

  task automatic chk(input string tag, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_cycle(input bit rv, input logic [19:0] va, input bit wr,
                          input bit pwe, input int ppid, input int pvpn,
                          input bit pv, input bit pw, input int pfn,
                          input bit cwe, input int cval, input string tag);
    int p, vp, wp;
    bit ef;
    int epa;
    @(negedge clk);
    req_valid = rv; req_vaddr = va; req_wr = wr;
    pte_we = pwe; pte_pid = 4'(ppid); pte_vpn = 4'(pvpn);
    pte_valid = pv; pte_wperm = pw; pte_pfn = 8'(pfn);
    cur_we = cwe; cur_wdata = 4'(cval);
    p  = (va[19:16] == 0) ? m_cur : int'(va[19:16]);
    vp = int'(va[15:12]);
    ef = !m_v[p][vp] || (wr && !m_w[p][vp]);
    epa = ef ? 0 : ((m_f[p][vp] << 12) | int'(va[11:0]));
    if (pwe) begin
      wp = (ppid == 0) ? m_cur : ppid;
      m_v[wp][pvpn] = pv; m_w[wp][pvpn] = pw; m_f[wp][pvpn] = pfn;
    end
    if (cwe && cval != 0) m_cur = cval;
    @(posedge clk);
    #2;
    chk(tag, rsp_valid == rv, int'(rsp_valid), int'(rv));
    if (rv) begin
      chk(tag, rsp_fault == ef, int'(rsp_fault), int'(ef));
      chk(tag, int'(rsp_paddr) == epa, int'(rsp_paddr), epa);
    end
  endtask

  function automatic logic [19:0] va_of(input int pid, input int vpn, input int off);
    return {4'(pid), 4'(vpn), 12'(off)};
  endfunction

  task automatic lookup(input int pid, input int vpn, input int off, input bit wr, input string tag);
    do_cycle(1, va_of(pid, vpn, off), wr, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic load(input int pid, input int vpn, input bit v, input bit w, input int pfn, input string tag);
    do_cycle(0, '0, 0, 1, pid, vpn, v, w, pfn, 0, 0, tag);
  endtask

  task automatic set_cur(input int val, input string tag);
    do_cycle(0, '0, 0, 0, 0, 0, 0, 0, 0, 1, val, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++) begin m_v[i][j] = 0; m_w[i][j] = 0; m_f[i][j] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #2;
    chk("R11 reset rsp_valid", rsp_valid == 1'b0, int'(rsp_valid), 0);
    // R11: all entries invalid after reset
    lookup(1, 0, 'h123, 0, "R11 empty table faults");
    lookup(7, 9, 'h000, 0, "R11 empty table faults");

    // R1 / R2: explicit process numbers
    load(1, 3, 1, 1, 'hA1, "R6 load");
    load(2, 3, 1, 0, 'hB2, "R6 load");
    load(3, 15, 1, 1, 'hFF, "R6 load");
    lookup(1, 3, 'hABC, 0, "R1 field split pid1");
    lookup(2, 3, 'h001, 0, "R2 explicit pid2 same page");
    lookup(3, 15, 'hFFF, 1, "R2 explicit pid3 write ok");
    lookup(4, 3, 'h010, 0, "R2 unmapped process faults");

    // R3: process zero aliases current (reset value 1, R4)
    lookup(0, 3, 'h555, 0, "R3 self alias reset cur");
    set_cur(2, "R4 load cur 2");
    lookup(0, 3, 'h777, 0, "R3 self alias cur 2");
    lookup(1, 3, 'h777, 0, "R2 explicit other process");

    // R4: same-cycle cur write and process-zero lookup uses old value
    do_cycle(1, va_of(0, 3, 'h321), 0, 0, 0, 0, 0, 0, 0, 1, 1, "R4 same cycle old cur");
    lookup(0, 3, 'h321, 0, "R4 new cur visible");

    // R5: zero write ignored
    set_cur(0, "R5 zero write");
    lookup(0, 3, 'h444, 0, "R5 cur unchanged");

    // R6: entry write with pid zero hits current process
    load(0, 8, 1, 1, 'h5C, "R6 alias load");
    lookup(1, 8, 'h0AA, 0, "R6 alias landed in pid1");
    lookup(2, 8, 'h0AA, 0, "R6 pid2 untouched");

    // R7 / R8: permission and invalid faults
    lookup(2, 3, 'h100, 1, "R7 write without permission faults");
    lookup(2, 3, 'h100, 0, "R7 read without permission ok");
    load(3, 15, 0, 1, 'hFF, "R7 invalidate");
    lookup(3, 15, 'hFFF, 0, "R8 invalid entry zero pa");

    // R9: back-to-back and bubble
    lookup(1, 3, 'h001, 0, "R9 back to back");
    lookup(1, 8, 'h002, 0, "R9 back to back");
    do_cycle(0, '0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 bubble");
    lookup(2, 3, 'h003, 0, "R9 after bubble");

    // R10: same-cycle entry write and lookup
    load(2, 5, 1, 1, 'h11, "R10 setup");
    do_cycle(1, va_of(2, 5, 'h0F0), 0, 1, 2, 5, 1, 1, 'h22, 0, 0, "R10 old contents");
    lookup(2, 5, 'h0F0, 0, "R10 new contents");
    // R10 with alias on both sides and a cur change in flight
    do_cycle(1, va_of(0, 5, 'h00F), 0, 1, 0, 5, 1, 0, 'h33, 1, 2, "R10 alias collision");
    lookup(1, 5, 'h00F, 0, "R10 alias write went to old cur");

    // randomized mix
    for (int k = 0; k < 2000; k++) begin
      do_cycle($urandom_range(0, 3) != 0, 20'($urandom), $urandom_range(0, 1),
               $urandom_range(0, 2) == 0, $urandom_range(0, 15), $urandom_range(0, 15),
               $urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 255),
               $urandom_range(0, 7) == 0, $urandom_range(0, 3), "R2 random mix");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule